// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control Unit

This block decides, for a scalar in-order integer pipeline of seven stages, whether the instruction now in decode may move into execute and where each of its two execute operands must be taken from once it gets there. The stages are fetch-tag, fetch-data, decode, execute, memory-tag, memory-data and writeback. Each memory access takes two stages, a tag check and then a data access, so a loaded value exists only at the end of memory-data. An ALU result exists at the end of execute.

The unit reads the two source register numbers of the decode instruction. From the execute, memory-tag, memory-data and writeback pipeline registers it reads the destination register and the write-enable, and from execute and memory-tag it also reads an is-load flag. It drives a hold signal for the fetch and decode stages and a bubble insert into execute. It registers one 2-bit operand select per source, so the select lines up with the instruction once that instruction sits in execute. A producer that is in stage S while the consumer is in decode is one stage further on when the consumer reaches execute, and the select names that later stage. As an option, the unit also flags a writeback-to-decode register read bypass.

Top module: `pipe_hazard_unit`

## Requirements
- R1: During reset and on the first cycle after it, both operand selects are 0.
- R2: When the youngest writer of a non-zero decode source is a load in execute, stall_front and bubble_ex are both 1 in that same cycle. This holds for either operand.
- R3: When the youngest writer of a non-zero decode source is a load in memory-tag, and execute does not write that register, stall_front and bubble_ex are both 1.
- R4: A load in memory-data that writes a decode source causes no stall. On the next cycle the select for that operand is 3.
- R5: A producer that is not a load (is-load 0) never causes a stall, whichever stage it is in.
- R6: On each clock edge where decode advances, each operand select is loaded with a code. The code is 1 if execute writes the source, 2 if memory-tag does and 3 if memory-data does. It is 0 otherwise, which covers the case where only writeback writes the source, since the register file handles that case.
- R7: When several stages write the same source, the code reflects the youngest of them (execute before memory-tag before memory-data). The stall decision also looks only at that youngest writer.
- R8: A source of register 0 never causes a stall, never gives a non-zero select and never raises the decode bypass flag.
- R9: A stage whose write-enable is 0 is ignored, even when its destination matches a source.
- R10: On the clock edge after a stall cycle, both operand selects are 0, because a bubble has entered execute.
- R11: With the bypass option enabled, dec_wb_byp_a and dec_wb_byp_b are 1 in the same cycle exactly when writeback writes the matching non-zero decode source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_rs_a | input | AW | First source register of the decode instruction |
| dec_rs_b | input | AW | Second source register of the decode instruction |
| ex_rd | input | AW | Destination register held in execute |
| ex_wen | input | 1 | Write-enable held in execute |
| ex_load | input | 1 | Execute instruction is a load |
| mt_rd | input | AW | Destination register held in memory-tag |
| mt_wen | input | 1 | Write-enable held in memory-tag |
| mt_load | input | 1 | Memory-tag instruction is a load |
| md_rd | input | AW | Destination register held in memory-data |
| md_wen | input | 1 | Write-enable held in memory-data |
| wb_rd | input | AW | Destination register held in writeback |
| wb_wen | input | 1 | Write-enable held in writeback |
| stall_front | output | 1 | Hold fetch-tag, fetch-data and decode |
| bubble_ex | output | 1 | Insert a bubble into execute |
| fwd_sel_a | output | 2 | Execute operand A source: 0 register file, 1 memory-tag, 2 memory-data, 3 writeback |
| fwd_sel_b | output | 2 | Execute operand B source, same encoding |
| dec_wb_byp_a | output | 1 | Decode read of source A must take the writeback value |
| dec_wb_byp_b | output | 1 | Decode read of source B must take the writeback value |

## Verification
The properties assume that the inputs are driven to stable values away from the clock edge. They also assume that the stage inputs describe what each pipeline register holds in that cycle. They do not assume that successive cycles form a pipeline that actually advances. This is why the stimulus can show the unit a fresh, unrelated combination of stage contents and decode sources in every cycle. The stimulus uses a reduced register file of four registers, so that register 0 and real overlaps between sources and destinations occur often. It sweeps every kind of producer (write-enable off, ALU or load) and every destination in execute, memory-tag and memory-data, against every pair of sources. Writeback is varied along with the other stages. The registered selects are compared one edge later with the values the model predicts for the cycle just swept.

// File: rtl/hfu_pkg.sv
package hfu_pkg;

   typedef enum logic [1:0] {
      SEL_RF = 2'd0,
      SEL_MT = 2'd1,
      SEL_MD = 2'd2,
      SEL_WB = 2'd3
   } fwd_sel_e;

   localparam int unsigned PRODUCER_STAGES = 3;

endpackage

// File: rtl/hfu_src_match.sv
module hfu_src_match
   import hfu_pkg::*;
#(
   parameter int unsigned AW             = 5,
   parameter bit          ZERO_REG_CONST = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_wen,
   input  logic          ex_load,
   input  logic [AW-1:0] mt_rd,
   input  logic          mt_wen,
   input  logic          mt_load,
   input  logic [AW-1:0] md_rd,
   input  logic          md_wen,
   output fwd_sel_e      sel_next,
   output logic          load_hazard
);

   logic [PRODUCER_STAGES-1:0][AW-1:0] prod_rd;
   logic [PRODUCER_STAGES-1:0]         prod_wen;
   logic [PRODUCER_STAGES-1:0]         hit;
   logic                               src_live;

   assign prod_rd  = {md_rd, mt_rd, ex_rd};
   assign prod_wen = {md_wen, mt_wen, ex_wen};

   if (ZERO_REG_CONST) begin : g_zero_const
      assign src_live = |src;
   end else begin : g_zero_plain
      assign src_live = 1'b1;
   end

   for (genvar s = 0; s < PRODUCER_STAGES; s++) begin : g_hit
      assign hit[s] = src_live && prod_wen[s] && (prod_rd[s] == src);
   end

   always_comb begin
      if (hit[0])      sel_next = SEL_MT;
      else if (hit[1]) sel_next = SEL_MD;
      else if (hit[2]) sel_next = SEL_WB;
      else             sel_next = SEL_RF;
   end

   assign load_hazard = (hit[0] && ex_load) || (!hit[0] && hit[1] && mt_load);

endmodule

// File: rtl/hfu_wb_bypass.sv
module hfu_wb_bypass #(
   parameter int unsigned AW             = 5,
   parameter bit          ENABLE         = 1'b1,
   parameter bit          ZERO_REG_CONST = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] wb_rd,
   input  logic          wb_wen,
   output logic          take_wb
);

   if (!ENABLE) begin : g_wbr
      logic unused_inputs;
      assign unused_inputs = ^{src, wb_rd, wb_wen};
      assign take_wb       = 1'b0;
   end else if (ZERO_REG_CONST) begin : g_byp_nz
      assign take_wb = wb_wen && (|src) && (wb_rd == src);
   end else begin : g_byp_any
      assign take_wb = wb_wen && (wb_rd == src);
   end

endmodule

// File: rtl/hfu_sel_reg.sv
module hfu_sel_reg #(
   parameter int unsigned NSRC = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bubble,
   input  logic [NSRC-1:0][1:0]       sel_d,
   output logic [NSRC-1:0][1:0]       sel_q
);

   for (genvar i = 0; i < NSRC; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n || bubble) sel_q[i] <= 2'd0;
         else                  sel_q[i] <= sel_d[i];
      end
   end

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
   import hfu_pkg::*;
#(
   parameter int unsigned REG_COUNT      = 32,
   parameter bit          WB_DEC_BYPASS  = 1'b1,
   parameter bit          ZERO_REG_CONST = 1'b1,
   localparam int unsigned AW            = $clog2(REG_COUNT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] dec_rs_a,
   input  logic [AW-1:0] dec_rs_b,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_wen,
   input  logic          ex_load,
   input  logic [AW-1:0] mt_rd,
   input  logic          mt_wen,
   input  logic          mt_load,
   input  logic [AW-1:0] md_rd,
   input  logic          md_wen,
   input  logic [AW-1:0] wb_rd,
   input  logic          wb_wen,
   output logic          stall_front,
   output logic          bubble_ex,
   output logic [1:0]    fwd_sel_a,
   output logic [1:0]    fwd_sel_b,
   output logic          dec_wb_byp_a,
   output logic          dec_wb_byp_b
);

   localparam int unsigned NSRC = 2;

   if (REG_COUNT < 2) begin : g_chk_count
      $error("pipe_hazard_unit: REG_COUNT must be at least 2");
   end
   if ((1 << AW) != REG_COUNT) begin : g_chk_pow2
      $error("pipe_hazard_unit: REG_COUNT must be a power of two");
   end

   logic [NSRC-1:0][AW-1:0] src;
   logic [NSRC-1:0][1:0]    sel_d;
   logic [NSRC-1:0][1:0]    sel_q;
   logic [NSRC-1:0]         hazard;
   logic [NSRC-1:0]         wb_take;
   logic                    stall;

   assign src = {dec_rs_b, dec_rs_a};

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      fwd_sel_e sel_e;

      hfu_src_match #(.AW(AW), .ZERO_REG_CONST(ZERO_REG_CONST)) u_match (
         .src         (src[i]),
         .ex_rd       (ex_rd),
         .ex_wen      (ex_wen),
         .ex_load     (ex_load),
         .mt_rd       (mt_rd),
         .mt_wen      (mt_wen),
         .mt_load     (mt_load),
         .md_rd       (md_rd),
         .md_wen      (md_wen),
         .sel_next    (sel_e),
         .load_hazard (hazard[i])
      );
      assign sel_d[i] = sel_e;

      hfu_wb_bypass #(.AW(AW), .ENABLE(WB_DEC_BYPASS), .ZERO_REG_CONST(ZERO_REG_CONST)) u_wb (
         .src     (src[i]),
         .wb_rd   (wb_rd),
         .wb_wen  (wb_wen),
         .take_wb (wb_take[i])
      );
   end

   assign stall = |hazard;

   hfu_sel_reg #(.NSRC(NSRC)) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .bubble (stall),
      .sel_d  (sel_d),
      .sel_q  (sel_q)
   );

   assign stall_front  = stall;
   assign bubble_ex    = stall;
   assign fwd_sel_a    = sel_q[0];
   assign fwd_sel_b    = sel_q[1];
   assign dec_wb_byp_a = wb_take[0];
   assign dec_wb_byp_b = wb_take[1];

endmodule

// File: rtl/hfu_checker.sv
module hfu_checker #(
   parameter int unsigned AW            = 5,
   parameter bit          WB_DEC_BYPASS = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] dec_rs_a,
   input logic [AW-1:0] dec_rs_b,
   input logic [AW-1:0] ex_rd,
   input logic          ex_wen,
   input logic          ex_load,
   input logic [AW-1:0] mt_rd,
   input logic          mt_wen,
   input logic          mt_load,
   input logic [AW-1:0] md_rd,
   input logic          md_wen,
   input logic [AW-1:0] wb_rd,
   input logic          wb_wen,
   input logic          stall_front,
   input logic          bubble_ex,
   input logic [1:0]    fwd_sel_a,
   input logic [1:0]    fwd_sel_b,
   input logic          dec_wb_byp_a,
   input logic          dec_wb_byp_b
);

   logic ex_hits_a, mt_hits_a, md_hits_a, any_load_writer;
   assign ex_hits_a = ex_wen && (dec_rs_a != '0) && (ex_rd == dec_rs_a);
   assign mt_hits_a = mt_wen && (dec_rs_a != '0) && (mt_rd == dec_rs_a);
   assign md_hits_a = md_wen && (dec_rs_a != '0) && (md_rd == dec_rs_a);
   assign any_load_writer = (ex_wen && ex_load) || (mt_wen && mt_load);

   AST_EX_LOAD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      ex_hits_a && ex_load |-> stall_front && bubble_ex); // R2
   AST_MT_LOAD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      mt_hits_a && mt_load && !ex_hits_a |-> stall_front); // R3
   AST_MD_LOAD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      md_hits_a && !ex_hits_a && !mt_hits_a && !stall_front |=> fwd_sel_a == 2'd3); // R4
   AST_ALU_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !any_load_writer |-> !stall_front); // R5
   AST_EX_FWD_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
      ex_hits_a && !stall_front |=> fwd_sel_a == 2'd1); // R7
   AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      dec_rs_a == '0 && dec_rs_b == '0 |=> fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0); // R8
   AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      dec_rs_a == '0 && dec_rs_b == '0 |-> !stall_front); // R8
   AST_BUBBLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_ex |=> fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0); // R10
   AST_WB_BYP_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_wb_byp_a || dec_wb_byp_b) |-> wb_wen && WB_DEC_BYPASS); // R11

endmodule

bind pipe_hazard_unit hfu_checker #(.AW(AW), .WB_DEC_BYPASS(WB_DEC_BYPASS)) u_hfu_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .dec_rs_a     (dec_rs_a),
   .dec_rs_b     (dec_rs_b),
   .ex_rd        (ex_rd),
   .ex_wen       (ex_wen),
   .ex_load      (ex_load),
   .mt_rd        (mt_rd),
   .mt_wen       (mt_wen),
   .mt_load      (mt_load),
   .md_rd        (md_rd),
   .md_wen       (md_wen),
   .wb_rd        (wb_rd),
   .wb_wen       (wb_wen),
   .stall_front  (stall_front),
   .bubble_ex    (bubble_ex),
   .fwd_sel_a    (fwd_sel_a),
   .fwd_sel_b    (fwd_sel_b),
   .dec_wb_byp_a (dec_wb_byp_a),
   .dec_wb_byp_b (dec_wb_byp_b)
);

// File: tb/pipe_hazard_unit_bench.sv
`timescale 1ns/1ps
module pipe_hazard_unit_bench;

   localparam int unsigned REGS = 4;
   localparam int unsigned AW   = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] dec_rs_a, dec_rs_b, ex_rd, mt_rd, md_rd, wb_rd;
   logic          ex_wen, ex_load, mt_wen, mt_load, md_wen, wb_wen;
   logic          stall_front, bubble_ex, dec_wb_byp_a, dec_wb_byp_b;
   logic [1:0]    fwd_sel_a, fwd_sel_b;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pipe_hazard_unit #(.REG_COUNT(REGS), .WB_DEC_BYPASS(1'b1), .ZERO_REG_CONST(1'b1)) u_pipe_hazard_unit (
      .clk(clk), .rst_n(rst_n),
      .dec_rs_a(dec_rs_a), .dec_rs_b(dec_rs_b),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
      .mt_rd(mt_rd), .mt_wen(mt_wen), .mt_load(mt_load),
      .md_rd(md_rd), .md_wen(md_wen),
      .wb_rd(wb_rd), .wb_wen(wb_wen),
      .stall_front(stall_front), .bubble_ex(bubble_ex),
      .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
      .dec_wb_byp_a(dec_wb_byp_a), .dec_wb_byp_b(dec_wb_byp_b)
   );

   task automatic check(input string tag, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (rs %0d/%0d ex %0d.%0d.%0d mt %0d.%0d.%0d md %0d.%0d)",
                  tag, actual, expected, dec_rs_a, dec_rs_b, ex_rd, ex_wen, ex_load,
                  mt_rd, mt_wen, mt_load, md_rd, md_wen);
      end
   endtask

   // Youngest writer stage index: 1 execute, 2 memory-tag, 3 memory-data, 0 none.
   function automatic int youngest(input int src);
      int y = 0;
      if (src == 0) return 0;
      if (md_wen && md_rd == src) y = 3;
      if (mt_wen && mt_rd == src) y = 2;
      if (ex_wen && ex_rd == src) y = 1;
      return y;
   endfunction

   function automatic bit src_hazard(input int src);
      int y = youngest(src);
      return (y == 1 && ex_load) || (y == 2 && mt_load);
   endfunction

   function automatic string stall_tag(input int src);
      int y = youngest(src);
      if (src == 0) return "R8";
      if (y == 1 && ex_load) return "R2";
      if (y == 2 && mt_load) return (ex_wen && ex_rd != src) ? "R3" : "R3";
      if (y == 2 && ex_load && ex_rd != src) return "R7";
      if ((ex_rd == src && !ex_wen) || (mt_rd == src && !mt_wen)) return "R9";
      return "R5";
   endfunction

   function automatic string sel_tag(input int src, input int y, input bit stalled);
      int writers;
      if (stalled) return "R10";
      if (src == 0) return "R8";
      writers = int'(ex_wen && ex_rd == src) + int'(mt_wen && mt_rd == src) + int'(md_wen && md_rd == src);
      if (writers > 1) return "R7";
      if (y == 3) return "R4";
      if ((ex_rd == src && !ex_wen) || (mt_rd == src && !mt_wen) || (md_rd == src && !md_wen)) return "R9";
      return "R6";
   endfunction

   task automatic set_stage(input int kind, output logic [AW-1:0] rd, output logic wen, output logic ld);
      rd  = AW'(kind % REGS);
      wen = (kind / REGS) != 0;
      ld  = (kind / REGS) == 2;
   endtask

   initial begin
      logic dummy;
      rst_n = 1'b0;
      dec_rs_a = '0; dec_rs_b = '0;
      ex_rd = '0; mt_rd = '0; md_rd = '0; wb_rd = '0;
      ex_wen = 0; ex_load = 0; mt_wen = 0; mt_load = 0; md_wen = 0; wb_wen = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 sel_a in reset", int'(fwd_sel_a), 0);
      check("R1 sel_b in reset", int'(fwd_sel_b), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 sel_a after reset", int'(fwd_sel_a), 0);
      check("R1 stall after reset", int'(stall_front), 0);

      for (int ex = 0; ex < 3 * REGS; ex++)
         for (int mt = 0; mt < 3 * REGS; mt++)
            for (int md = 0; md < 3 * REGS; md++)
               for (int ab = 0; ab < REGS * REGS; ab++) begin
                  int  wbk, ya, yb;
                  bit  exp_stall;
                  @(negedge clk);
                  set_stage(ex, ex_rd, ex_wen, ex_load);
                  set_stage(mt, mt_rd, mt_wen, mt_load);
                  set_stage(md, md_rd, md_wen, dummy);
                  wbk = (ex + mt + md + ab) % (2 * REGS);
                  wb_rd  = AW'(wbk % REGS);
                  wb_wen = (wbk / REGS) != 0;
                  dec_rs_a = AW'(ab % REGS);
                  dec_rs_b = AW'(ab / REGS);
                  #1;
                  exp_stall = src_hazard(int'(dec_rs_a)) || src_hazard(int'(dec_rs_b));
                  check(src_hazard(int'(dec_rs_b)) ? stall_tag(int'(dec_rs_b)) : stall_tag(int'(dec_rs_a)),
                        int'(stall_front), int'(exp_stall));
                  check("R2 bubble", int'(bubble_ex), int'(exp_stall));
                  check("R11 byp_a", int'(dec_wb_byp_a), int'(wb_wen && dec_rs_a != 0 && wb_rd == dec_rs_a));
                  check("R11 byp_b", int'(dec_wb_byp_b), int'(wb_wen && dec_rs_b != 0 && wb_rd == dec_rs_b));
                  ya = youngest(int'(dec_rs_a));
                  yb = youngest(int'(dec_rs_b));
                  @(posedge clk); #1;
                  check(sel_tag(int'(dec_rs_a), ya, exp_stall), int'(fwd_sel_a), exp_stall ? 0 : ya);
                  check(sel_tag(int'(dec_rs_b), yb, exp_stall), int'(fwd_sel_b), exp_stall ? 0 : yb);
               end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule